// File: doc/BRIEF.md
# Page Table Address Translator

This block maps a virtual address to a physical address using a small page table that is kept in on-chip flip-flops. The upper bits of the virtual address choose one table entry. The lower bits are the byte offset inside a 4 KB page, and they pass through unchanged. Each entry has a presence flag, a physical frame number, a read-only flag and a do-not-cache flag.

A lookup states its access type, read or write. Exactly one cycle later the block returns one of three results: the translated address together with the entry's cacheability flag, a page fault, or a protection fault. A page fault means the entry is absent. A protection fault means a write was attempted to a read-only page. Software or a controller loads entries through a single write port, one entry per cycle. Disk handling, replacement and any translation cache are left to other logic.

Top module: `ptt_xlate`

## Requirements
- R1: After reset every entry is absent, and `res_valid`, both fault outputs, `res_paddr` and `res_nocache` are 0.
- R2: A lookup presented with `lk_valid`=1 at a rising edge produces its result on the outputs after that edge. `res_valid` is 1 for exactly that cycle. A cycle without a lookup gives `res_valid`=0, both faults 0, `res_paddr`=0 and `res_nocache`=0.
- R3: For a present entry with no fault, `res_paddr` = {frame[7:0], vaddr[11:0]}. The page index is vaddr[15:12], and the offset bits are copied unchanged.
- R4: A lookup of an absent entry gives `res_page_fault`=1, `res_paddr`=0 and `res_nocache`=0.
- R5: A write (`lk_write`=1) to a present read-only entry gives `res_prot_fault`=1 and `res_paddr`=0. A read of the same entry translates normally.
- R6: When an entry is both absent and read-only, a write lookup reports only the page fault. The two fault outputs are never 1 together.
- R7: On a successful translation, `res_nocache` equals the entry's do-not-cache flag.
- R8: A table write to the same entry in the same cycle as a lookup gives the lookup the old contents. The new contents take effect from the next lookup.
- R9: A table write with `wr_en`=1 replaces all fields of entry `wr_page` and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table entry |
| wr_page | input | 4 | Entry index to write |
| wr_present | input | 1 | Presence flag to store |
| wr_ro | input | 1 | Read-only flag to store |
| wr_nc | input | 1 | Do-not-cache flag to store |
| wr_frame | input | 8 | Frame number to store |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Access type, 1 = write |
| lk_vaddr | input | 16 | Virtual address |
| res_valid | output | 1 | Result present this cycle |
| res_paddr | output | 20 | Physical address, 0 on fault |
| res_nocache | output | 1 | Do-not-cache flag of the translated page |
| res_page_fault | output | 1 | Entry absent |
| res_prot_fault | output | 1 | Write to a read-only page |

## Verification
Every result is registered once, so it appears on the outputs one cycle after the edge that captured the lookup. A table write changes the entry at the edge where `wr_en` is sampled. The bench drives its inputs on falling edges. It lets one rising edge pass and then reads every output on the next falling edge, which is the first point where the registered result can be seen. The same-cycle collision case drives the write and the lookup on the same falling edge. The bench expects the old entry from that lookup, and it expects the new entry from a second lookup one cycle later.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    // Absence is tested before access rights.
    function automatic fault_e classify(input logic present, input logic ro, input logic is_write);
        if (!present)
            return FLT_PAGE;
        else if (ro && is_write)
            return FLT_PROT;
        else
            return FLT_NONE;
    endfunction

endpackage

// File: rtl/ptt_table.sv
module ptt_table #(
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic               wr_present,
    input  logic               wr_ro,
    input  logic               wr_nc,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [PAGE_W-1:0]  rd_page,
    output logic               rd_present,
    output logic               rd_ro,
    output logic               rd_nc,
    output logic [FRAME_W-1:0] rd_frame
);
    localparam int DEPTH = 1 << PAGE_W;

    typedef struct packed {
        logic               present;
        logic               ro;
        logic               nc;
        logic [FRAME_W-1:0] frame;
    } ent_t;

    ent_t ent_q [DEPTH];
    ent_t ent_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_page] = '{present: wr_present, ro: wr_ro, nc: wr_nc, frame: wr_frame};
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else
                ent_q[g] <= ent_d[g];
        end
    end

    // Read the registered state, so a write in the same cycle is not seen.
    always_comb begin
        rd_present = ent_q[rd_page].present;
        rd_ro      = ent_q[rd_page].ro;
        rd_nc      = ent_q[rd_page].nc;
        rd_frame   = ent_q[rd_page].frame;
    end
endmodule

// File: rtl/ptt_eval.sv
module ptt_eval #(
    parameter int OFS_W   = 12,
    parameter int FRAME_W = 8,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic               present,
    input  logic               ro,
    input  logic               nc,
    input  logic [FRAME_W-1:0] frame,
    output logic               out_valid,
    output logic               out_page_fault,
    output logic               out_prot_fault,
    output logic               out_nc,
    output logic [PA_W-1:0]    out_paddr
);
    import ptt_pkg::*;

    fault_e flt;
    logic   ok;

    always_comb begin
        flt            = classify(present, ro, req_write);
        ok             = req_valid && (flt == FLT_NONE);
        out_valid      = req_valid;
        out_page_fault = req_valid && (flt == FLT_PAGE);
        out_prot_fault = req_valid && (flt == FLT_PROT);
        out_nc         = ok && nc;
        out_paddr      = ok ? {frame, req_ofs} : '0;
    end
endmodule

// File: rtl/ptt_xlate.sv
module ptt_xlate #(
    parameter int OFS_W   = 12,
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 8,
    localparam int VA_W   = PAGE_W + OFS_W,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic               wr_present,
    input  logic               wr_ro,
    input  logic               wr_nc,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               lk_valid,
    input  logic               lk_write,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               res_valid,
    output logic [PA_W-1:0]    res_paddr,
    output logic               res_nocache,
    output logic               res_page_fault,
    output logic               res_prot_fault
);
    typedef struct packed {
        logic            valid;
        logic            page_fault;
        logic            prot_fault;
        logic            nc;
        logic [PA_W-1:0] paddr;
    } res_t;

    res_t res_d, res_q;

    logic               e_present, e_ro, e_nc;
    logic [FRAME_W-1:0] e_frame;
    logic               v_valid, v_pf, v_prf, v_nc;
    logic [PA_W-1:0]    v_paddr;

    ptt_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_page    (wr_page),
        .wr_present (wr_present),
        .wr_ro      (wr_ro),
        .wr_nc      (wr_nc),
        .wr_frame   (wr_frame),
        .rd_page    (lk_vaddr[VA_W-1:OFS_W]),
        .rd_present (e_present),
        .rd_ro      (e_ro),
        .rd_nc      (e_nc),
        .rd_frame   (e_frame)
    );

    ptt_eval #(.OFS_W(OFS_W), .FRAME_W(FRAME_W)) u_eval (
        .req_valid      (lk_valid),
        .req_write      (lk_write),
        .req_ofs        (lk_vaddr[OFS_W-1:0]),
        .present        (e_present),
        .ro             (e_ro),
        .nc             (e_nc),
        .frame          (e_frame),
        .out_valid      (v_valid),
        .out_page_fault (v_pf),
        .out_prot_fault (v_prf),
        .out_nc         (v_nc),
        .out_paddr      (v_paddr)
    );

    always_comb begin
        res_d            = '0;
        res_d.valid      = v_valid;
        res_d.page_fault = v_pf;
        res_d.prot_fault = v_prf;
        res_d.nc         = v_nc;
        res_d.paddr      = v_paddr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign res_valid      = res_q.valid;
    assign res_paddr      = res_q.paddr;
    assign res_nocache    = res_q.nc;
    assign res_page_fault = res_q.page_fault;
    assign res_prot_fault = res_q.prot_fault;
endmodule

// File: rtl/ptt_sva.sv
module ptt_sva #(
    parameter int OFS_W   = 12,
    parameter int PAGE_W  = 4,
    parameter int FRAME_W = 8,
    localparam int VA_W   = PAGE_W + OFS_W,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_write,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              res_valid,
    input logic [PA_W-1:0]   res_paddr,
    input logic              res_nocache,
    input logic              res_page_fault,
    input logic              res_prot_fault
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_page_fault && !res_prot_fault && res_paddr == '0));

    p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_page_fault || res_prot_fault
                      || res_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

    p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_page_fault || res_prot_fault) |-> (res_paddr == '0 && !res_nocache));

    p_read_no_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_write) |=> !res_prot_fault);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_page_fault && res_prot_fault));
endmodule

bind ptt_xlate ptt_sva #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_write       (lk_write),
    .lk_vaddr       (lk_vaddr),
    .res_valid      (res_valid),
    .res_paddr      (res_paddr),
    .res_nocache    (res_nocache),
    .res_page_fault (res_page_fault),
    .res_prot_fault (res_prot_fault)
);

// File: tb/sim_ptt_xlate.sv
`timescale 1ns/1ps
module sim_ptt_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_page = '0;
    logic        wr_present = 1'b0, wr_ro = 1'b0, wr_nc = 1'b0;
    logic [7:0]  wr_frame = '0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [15:0] lk_vaddr = '0;
    logic        res_valid, res_nocache, res_page_fault, res_prot_fault;
    logic [19:0] res_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ptt_xlate u0 (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] pg, input logic p, input logic ro, input logic nc, input logic [7:0] fr);
        wr_en = 1'b1; wr_page = pg; wr_present = p; wr_ro = ro; wr_nc = nc; wr_frame = fr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive at a falling edge, capture at the rising edge, read at the next falling edge.
    task automatic look(input string req, input logic wr, input logic [15:0] va,
                        input logic pf, input logic prf, input logic nc, input logic [19:0] pa);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "valid", {31'b0, res_valid}, 32'd1);
        chk(req, "page_fault", {31'b0, res_page_fault}, {31'b0, pf});
        chk(req, "prot_fault", {31'b0, res_prot_fault}, {31'b0, prf});
        chk(req, "nocache", {31'b0, res_nocache}, {31'b0, nc});
        chk(req, "paddr", {12'b0, res_paddr}, {12'b0, pa});
    endtask

    task automatic t_reset;
        chk("R1", "valid", {31'b0, res_valid}, 32'd0);
        chk("R1", "paddr", {12'b0, res_paddr}, 32'd0);
        look("R1", 1'b0, 16'h5123, 1'b1, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R2", "idle valid", {31'b0, res_valid}, 32'd0);
        chk("R2", "idle faults", {30'b0, res_page_fault, res_prot_fault}, 32'd0);
    endtask

    task automatic t_map;
        put(4'h1, 1'b1, 1'b0, 1'b0, 8'hA7);
        put(4'hF, 1'b1, 1'b0, 1'b0, 8'h3C);
        look("R3", 1'b0, 16'h1ABC, 1'b0, 1'b0, 1'b0, 20'hA7ABC);
        look("R3", 1'b1, 16'hF000, 1'b0, 1'b0, 1'b0, 20'h3C000);
        look("R3", 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 20'h3CFFF);
        look("R9", 1'b0, 16'h2000, 1'b1, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic t_absent;
        put(4'h4, 1'b0, 1'b0, 1'b1, 8'h55);
        look("R4", 1'b0, 16'h4010, 1'b1, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic t_readonly;
        put(4'h7, 1'b1, 1'b1, 1'b0, 8'h2D);
        look("R5", 1'b1, 16'h7444, 1'b0, 1'b1, 1'b0, 20'h0);
        look("R5", 1'b0, 16'h7444, 1'b0, 1'b0, 1'b0, 20'h2D444);
    endtask

    task automatic t_priority;
        put(4'h9, 1'b0, 1'b1, 1'b0, 8'h11);
        look("R6", 1'b1, 16'h9001, 1'b1, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic t_nocache;
        put(4'h3, 1'b1, 1'b0, 1'b1, 8'hE0);
        look("R7", 1'b0, 16'h3F0F, 1'b0, 1'b0, 1'b1, 20'hE0F0F);
        put(4'h3, 1'b1, 1'b0, 1'b0, 8'hE0);
        look("R9", 1'b0, 16'h3F0F, 1'b0, 1'b0, 1'b0, 20'hE0F0F);
        look("R9", 1'b0, 16'h1001, 1'b0, 1'b0, 1'b0, 20'hA7001);
    endtask

    task automatic t_collide;
        put(4'h6, 1'b1, 1'b0, 1'b0, 8'h40);
        wr_en = 1'b1; wr_page = 4'h6; wr_present = 1'b1; wr_ro = 1'b0; wr_nc = 1'b1; wr_frame = 8'h81;
        lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = 16'h6123;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        chk("R8", "old paddr", {12'b0, res_paddr}, 32'h40123);
        chk("R8", "old nocache", {31'b0, res_nocache}, 32'd0);
        look("R8", 1'b0, 16'h6123, 1'b0, 1'b0, 1'b1, 20'h81123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_map();
        t_absent();
        t_readonly();
        t_priority();
        t_nocache();
        t_collide();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule